// File: doc/BRIEF.md
# Fractional Clock Enable Divider

This block turns a fast input clock into a slower rate that is correct on average. It produces two outputs. The first is a strobe that is high for exactly one input cycle at the start of every output period, for logic that stays in the input clock domain. The second is a divided clock whose duty cycle is as close to even as a whole number of input cycles allows, for feeding a pin or a serial interface. Three parameters select the behaviour: the input frequency, the target output frequency, and a switch that picks fractional or rounded-integer division.

At elaboration the block forms a fixed-point period: the input frequency scaled by 2^16, divided by the output frequency. A 13-bit whole-cycle count sits above a 16-bit fraction. A fractional accumulator adds the fraction once per output period. Each time it carries, that period is one input cycle longer. The long-term average rate therefore lands within about a hertz of the target, instead of snapping to the nearest integer ratio. For example, a 1.789 MHz target from 100 MHz yields 17890 strobes in 10 ms. With fractional division switched off, the period is rounded to the nearest whole cycle and every period has the same length.

Top module: `fracClkDivider`

## Requirements
- R1: With fractional division on, let P = floor(IN_HZ * 65536 / OUT_HZ). The integer part is P[28:16] and the fraction is P[15:0]. Strobe number k, counting the first strobe after reset as number 0, occurs exactly floor(k * P / 65536) input cycles after strobe 0.
- R2: With fractional division off, the period is (P + 32768) with its low 16 bits dropped, and the fraction is zero. Every strobe interval then equals that integer: 56 cycles for 100 MHz to 1.789 MHz.
- R3: `clkEnable` is high for exactly one input cycle per output period and is never high in two consecutive cycles.
- R4: With fractional division on, the interval between successive strobes is always the integer part or the integer part plus one.
- R5: `clkOut` rises in the same cycle as `clkEnable`. In a period of L input cycles it stays high for floor(L/2) cycles, then stays low until the next strobe.
- R6: `rst` is synchronous and active high. While it is sampled high, `clkEnable` and `clkOut` are low and the counter and accumulator are cleared. The first strobe appears in the first cycle after the first rising edge with `rst` low, and the strobe pattern restarts from the same phase after every reset.
- R7: For 100 MHz to 1.789 MHz with fractional division on, exactly 1790 strobes fall within the 100000 input cycles that begin at strobe 0. Strobe 1789 is at offset 99999 and strobe 1790 is at offset 100055.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst | input | 1 | Synchronous active-high reset |
| clkEnable | output | 1 | One-cycle strobe at the start of each output period |
| clkOut | output | 1 | Divided clock, high for the first half of each period |

## Verification
The bench builds three copies of the block side by side.
- **100 MHz to 1.789 MHz, fractional.** Periods alternate irregularly between 55 and 56 cycles. This copy reaches the long 100000-cycle count window and checks the exact position of individual strobes against the closed-form floor(k*P/65536).
- **Same frequencies, rounded-integer.** This copy shows that the rounding step gives a fixed 56-cycle period.
- **100 MHz to 33 MHz, fractional.** Periods of three and four cycles exercise the odd-length duty split and the shortest counter reload.

Repeated resets, applied at arbitrary phases between runs, check that all three copies restart in the same place.

// File: rtl/fracClkDividerPkg.sv
package fracClkDividerPkg;

  // Strobes from the period control to the datapath.
  typedef struct packed {
    logic periodStart;  // next cycle begins a new output period
    logic dropClk;      // next cycle is the first low half-period cycle
  } divCtl_t;

endpackage

// File: rtl/fracClkDividerDp.sv
module fracClkDividerDp
  import fracClkDividerPkg::*;
#(
  parameter int unsigned INT_W = 13,
  parameter int unsigned FRAC_W = 16,
  parameter bit USE_FRAC = 1'b1,
  parameter logic [INT_W-1:0] INT_PERIOD = 55,
  parameter logic [FRAC_W-1:0] FRAC_PERIOD = 0
) (
  input  logic clk,
  input  logic rst,
  input  divCtl_t ctl,
  output logic [INT_W:0] periodLen,
  output logic strobe,
  output logic divClk
);

  logic carry;

  generate
    if (USE_FRAC) begin : g_accum
      logic [FRAC_W-1:0] acc;
      logic [FRAC_W:0] accSum;

      assign accSum = {1'b0, acc} + {1'b0, FRAC_PERIOD};
      assign carry = accSum[FRAC_W];

      always_ff @(posedge clk) begin
        if (rst) begin
          acc <= '0;
        end else if (ctl.periodStart) begin
          acc <= accSum[FRAC_W-1:0];
        end
      end
    end else begin : g_noAccum
      assign carry = 1'b0;
    end
  endgenerate

  // Length of the period that starts on the next load.
  assign periodLen = {1'b0, INT_PERIOD} + {{INT_W{1'b0}}, carry};

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe <= 1'b0;
      divClk <= 1'b0;
    end else begin
      strobe <= ctl.periodStart;
      if (ctl.periodStart) begin
        divClk <= 1'b1;
      end else if (ctl.dropClk) begin
        divClk <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/fracClkDividerCtl.sv
module fracClkDividerCtl
  import fracClkDividerPkg::*;
#(
  parameter int unsigned INT_W = 13
) (
  input  logic clk,
  input  logic rst,
  input  logic [INT_W:0] periodLen,
  output divCtl_t ctl
);

  localparam logic [INT_W:0] ONE = {{INT_W{1'b0}}, 1'b1};

  logic [INT_W:0] cnt;     // cycles left in the current period
  logic [INT_W:0] curLen;  // length of the current period

  assign ctl.periodStart = (cnt == '0);
  // Elapsed count in the next cycle is curLen - cnt; the clock drops at half.
  assign ctl.dropClk = !ctl.periodStart && (cnt == (curLen - (curLen >> 1)));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      curLen <= '0;
    end else if (ctl.periodStart) begin
      cnt <= periodLen - ONE;
      curLen <= periodLen;
    end else begin
      cnt <= cnt - ONE;
    end
  end

endmodule

// File: rtl/fracClkDivider.sv
module fracClkDivider
  import fracClkDividerPkg::*;
#(
  parameter longint unsigned IN_HZ = 100_000_000,
  parameter longint unsigned OUT_HZ = 1_789_000,
  parameter bit USE_FRAC = 1'b1,
  parameter int unsigned FRAC_W = 16,
  parameter int unsigned INT_W = 13
) (
  input  logic clk,
  input  logic rst,
  output logic clkEnable,
  output logic clkOut
);

  // Fixed-point period, FRAC_W fractional bits.
  localparam logic [63:0] P_SCALED = (64'(IN_HZ) << FRAC_W) / 64'(OUT_HZ);
  localparam logic [63:0] P_ROUND = P_SCALED + (64'd1 << (FRAC_W - 1));
  localparam logic [63:0] P_SEL = USE_FRAC ? P_SCALED : P_ROUND;
  localparam logic [INT_W-1:0] INT_PERIOD = P_SEL[FRAC_W +: INT_W];
  localparam logic [FRAC_W-1:0] FRAC_PERIOD = USE_FRAC ? P_SCALED[FRAC_W-1:0] : '0;

  divCtl_t ctl;
  logic [INT_W:0] periodLen;

  fracClkDividerCtl #(
    .INT_W(INT_W)
  ) i_ctl (
    .clk(clk),
    .rst(rst),
    .periodLen(periodLen),
    .ctl(ctl)
  );

  fracClkDividerDp #(
    .INT_W(INT_W),
    .FRAC_W(FRAC_W),
    .USE_FRAC(USE_FRAC),
    .INT_PERIOD(INT_PERIOD),
    .FRAC_PERIOD(FRAC_PERIOD)
  ) i_dp (
    .clk(clk),
    .rst(rst),
    .ctl(ctl),
    .periodLen(periodLen),
    .strobe(clkEnable),
    .divClk(clkOut)
  );

endmodule

// File: rtl/fracClkDividerChecker.sv
module fracClkDividerChecker #(
  parameter int unsigned INT_W = 13,
  parameter int unsigned INT_PERIOD = 55,
  parameter bit USE_FRAC = 1'b1
) (
  input logic clk,
  input logic rst,
  input logic stb,
  input logic divClk
);

  localparam logic [INT_W+1:0] GAP_LO = (INT_W + 2)'(INT_PERIOD);
  localparam logic [INT_W+1:0] GAP_HI = (INT_W + 2)'(INT_PERIOD + 1);

  logic [INT_W+1:0] gap;  // cycles since the previous strobe
  logic seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap <= '0;
      seen <= 1'b0;
    end else if (stb) begin
      gap <= (INT_W + 2)'(1);
      seen <= 1'b1;
    end else begin
      gap <= gap + (INT_W + 2)'(1);
    end
  end

  assert_strobe_single_R3: assert property (@(posedge clk) disable iff (rst)
    stb |=> !stb);

  assert_gap_bounds_R4: assert property (@(posedge clk) disable iff (rst)
    (stb && seen) |-> (gap == GAP_LO || gap == GAP_HI));

  assert_clk_rises_with_strobe_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(divClk) |-> stb);

  assert_strobe_clk_high_R5: assert property (@(posedge clk) disable iff (rst)
    stb |-> divClk);

  assert_reset_quiet_R6: assert property (@(posedge clk)
    rst |=> (!stb && !divClk));

  generate
    if (!USE_FRAC) begin : g_intMode
      assert_fixed_gap_R2: assert property (@(posedge clk) disable iff (rst)
        (stb && seen) |-> (gap == GAP_LO));
    end
  endgenerate

endmodule

bind fracClkDivider fracClkDividerChecker #(
  .INT_W(INT_W),
  .INT_PERIOD(INT_PERIOD),
  .USE_FRAC(USE_FRAC)
) i_checker (
  .clk(clk),
  .rst(rst),
  .stb(clkEnable),
  .divClk(clkOut)
);

// File: tb/test_fracClkDivider.sv
`timescale 1ns/1ps

module strobeWatch (
  input  logic clk,
  input  logic rst,
  input  logic stb,
  input  logic dclk,
  output int count,
  output int lastOffset,
  output int firstCycle,
  output int minGap,
  output int maxGap,
  output int dutyErr,
  output int wideErr
);
  int cyc, prevCyc, highRun, gapNow;
  bit lowSeen, prevStb;

  always @(negedge clk) begin
    if (rst) begin
      cyc = 0; prevCyc = 0; highRun = 0; lowSeen = 0; prevStb = 0;
      count = 0; lastOffset = 0; firstCycle = 0;
      minGap = 1 << 30; maxGap = 0; dutyErr = 0; wideErr = 0;
    end else begin
      cyc++;
      if (stb && prevStb) wideErr++;
      if (stb) begin
        if (!dclk) dutyErr++;
        if (count == 0) begin
          firstCycle = cyc;
        end else begin
          gapNow = cyc - prevCyc;
          if (gapNow < minGap) minGap = gapNow;
          if (gapNow > maxGap) maxGap = gapNow;
          if (highRun != gapNow / 2) dutyErr++;
        end
        prevCyc = cyc;
        lastOffset = cyc - firstCycle;
        count++;
        highRun = 1;
        lowSeen = 0;
      end else if (count > 0) begin
        if (dclk) begin
          if (lowSeen) dutyErr++;
          else highRun++;
        end else begin
          lowSeen = 1;
        end
      end
      prevStb = stb;
    end
  end
endmodule

module test_fracClkDivider;

  localparam longint IN_HZ = 100_000_000;
  localparam longint OUT_A = 1_789_000;
  localparam longint OUT_C = 33_000_000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stb [3];
  logic dclk [3];

  int wCount [3], wOff [3], wFirst [3], wMin [3], wMax [3], wDuty [3], wWide [3];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  fracClkDivider #(.IN_HZ(IN_HZ), .OUT_HZ(OUT_A), .USE_FRAC(1'b1)) i_fracClkDivider (
    .clk(clk), .rst(rst), .clkEnable(stb[0]), .clkOut(dclk[0]));
  fracClkDivider #(.IN_HZ(IN_HZ), .OUT_HZ(OUT_A), .USE_FRAC(1'b0)) i_fracClkDivider_int (
    .clk(clk), .rst(rst), .clkEnable(stb[1]), .clkOut(dclk[1]));
  fracClkDivider #(.IN_HZ(IN_HZ), .OUT_HZ(OUT_C), .USE_FRAC(1'b1)) i_fracClkDivider_fast (
    .clk(clk), .rst(rst), .clkEnable(stb[2]), .clkOut(dclk[2]));

  for (genvar g = 0; g < 3; g++) begin : g_watch
    strobeWatch i_watch (.clk(clk), .rst(rst), .stb(stb[g]), .dclk(dclk[g]),
      .count(wCount[g]), .lastOffset(wOff[g]), .firstCycle(wFirst[g]),
      .minGap(wMin[g]), .maxGap(wMax[g]), .dutyErr(wDuty[g]), .wideErr(wWide[g]));
  end

  function automatic longint periodOf(int inst);
    longint p;
    p = (IN_HZ << 16) / ((inst == 2) ? OUT_C : OUT_A);
    if (inst == 1) p = ((p + 32768) >> 16) << 16;
    return p;
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  typedef struct packed { int inst; int k; } vec_t;
  localparam vec_t VECS [12] = '{
    '{inst: 0, k: 1},      // R1
    '{inst: 0, k: 2},      // R1
    '{inst: 0, k: 37},     // R1
    '{inst: 0, k: 1000},   // R1
    '{inst: 0, k: 1789},   // R7 last strobe inside the window
    '{inst: 0, k: 1790},   // R7 first strobe outside the window
    '{inst: 1, k: 1},      // R2
    '{inst: 1, k: 2},      // R2
    '{inst: 1, k: 300},    // R2
    '{inst: 2, k: 1},      // R1
    '{inst: 2, k: 5},      // R1
    '{inst: 2, k: 10000}   // R1
  };

  task automatic doReset();
    @(negedge clk); #1 rst = 1'b1;
    repeat (3) begin
      @(negedge clk); #2;
      for (int i = 0; i < 3; i++) begin
        chk(!stb[i] && !dclk[i], "R6", "outputs low in reset", {stb[i], dclk[i]}, 0);
      end
    end
    rst = 1'b0;
    @(negedge clk); #1;
    for (int i = 0; i < 3; i++) begin
      chk(wFirst[i] == 1 && wCount[i] == 1, "R6", "first strobe cycle after release",
          wFirst[i], 1);
    end
  endtask

  task automatic finishPhase(int inst);
    longint ip;
    ip = periodOf(inst) >> 16;
    chk(wWide[inst] == 0, "R3", "strobe wider than one cycle", wWide[inst], 0);
    chk(wDuty[inst] == 0, "R5", "divided clock shape errors", wDuty[inst], 0);
    if (inst == 1) begin
      chk(wMin[inst] == ip && wMax[inst] == ip, "R2", "fixed interval", wMax[inst], ip);
    end else begin
      chk(wMin[inst] >= ip && wMax[inst] <= ip + 1, "R4", "interval bounds min",
          wMin[inst], ip);
      chk(wMax[inst] <= ip + 1, "R4", "interval bounds max", wMax[inst], ip + 1);
    end
  endtask

  initial begin
    int curInst;
    longint expOff;
    string tag;
    curInst = -1;
    // Reset state before any release: R6
    @(negedge clk); #2;
    for (int i = 0; i < 3; i++) begin
      chk(!stb[i] && !dclk[i], "R6", "outputs low at start", {stb[i], dclk[i]}, 0);
    end
    foreach (VECS[n]) begin
      if (VECS[n].inst != curInst) begin
        if (curInst >= 0) finishPhase(curInst);
        doReset();
        curInst = VECS[n].inst;
      end
      while (wCount[curInst] < VECS[n].k + 1) begin
        @(negedge clk); #1;
      end
      expOff = (longint'(VECS[n].k) * periodOf(curInst)) >> 16;
      if (curInst == 1) tag = "R2";
      else if (VECS[n].k >= 1789 && curInst == 0) tag = "R7";
      else tag = "R1";
      chk(wOff[curInst] == expOff, tag, $sformatf("offset of strobe %0d", VECS[n].k),
          wOff[curInst], expOff);
    end
    finishPhase(curInst);
    // Reset at an arbitrary mid-period phase, then confirm identical restart: R6
    repeat (17) @(negedge clk);
    doReset();
    while (wCount[0] < 3) begin
      @(negedge clk); #1;
    end
    expOff = (64'd2 * periodOf(0)) >> 16;
    chk(wOff[0] == expOff, "R6", "phase after mid-run reset", wOff[0], expOff);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule